// File: doc/BRIEF.md
# Bitfield Manipulation Execution Unit

This unit is a single-stage execute slot for a small processor pipeline. It performs operations on contiguous groups of bits inside 32-bit operands. It takes an operation code, a destination operand, a source operand, a field start position and a field width.

It can zero a field or overwrite a field with low-aligned source bits. It can pull a field out of the source, either zero-filled or sign-filled. It can also widen a byte or halfword of the source, again zero-filled or sign-filled. A single mask generator, driven by position and width, serves every field operation. Position/width pairs that would run past the top bit are flagged as illegal, and the destination is returned unchanged in that case.

Operands enter on a valid/ready stream and leave on a second valid/ready stream one clock later, through a single output register.

Back-pressure rules:
- The input is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output holds and no new input is taken.

The unit never touches condition flags. Its flag write enable toward the pipeline is tied low.

Top module: `bitfield_unit`

## Requirements
- R1: Operation code 0 (clear) returns the destination with bits lsb through lsb+width-1 forced to 0 and every other bit unchanged.
- R2: Operation code 1 (insert) returns the destination with bits lsb through lsb+width-1 replaced by source bits 0 through width-1, and every other bit unchanged.
- R3: Operation code 3 (unsigned extract) returns source bits lsb through lsb+width-1 in result bits 0 through width-1, with zeros above.
- R4: Operation code 2 (signed extract) returns the same field as R3, with source bit lsb+width-1 copied into every result bit from width upward.
- R5: Operation codes 4 and 5 sign-extend source bits [7:0] and [15:0] respectively. Codes 6 and 7 zero-extend source bits [7:0] and [15:0] respectively.
- R6: For codes 0 to 3, a width of 0 or lsb+width greater than 32 sets `out_illegal` to 1 and makes the result equal to the destination operand. Otherwise `out_illegal` is 0.
- R7: For codes 4 to 7, lsb and width have no effect on the result, and `out_illegal` is 0.
- R8: An input accepted on clock edge N is presented with `out_valid` high after edge N.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_result` and `out_illegal` stay unchanged.
- R10: When `rst` is sampled high at a clock edge, `out_valid` is 0 after that edge.
- R11: `out_flag_we` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Unit can take operands this cycle |
| in_op | input | 3 | Operation code (0 clear, 1 insert, 2 signed extract, 3 unsigned extract, 4 sign-extend byte, 5 sign-extend halfword, 6 zero-extend byte, 7 zero-extend halfword) |
| in_dst | input | 32 | Destination operand value |
| in_src | input | 32 | Source operand value |
| in_lsb | input | 5 | Field start bit |
| in_width | input | 6 | Field width in bits |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Value to write back |
| out_illegal | output | 1 | Position/width pair was out of range |
| out_flag_we | output | 1 | Flag write enable, always 0 |

## Verification
A result can be drained and a new operation accepted on the same clock edge. The bench provokes this by stalling the output with a pending result, holding a second operation at the input, and then raising `out_ready`. It expects the first result to stay frozen during the stall and the second result to appear right after the release edge, with no gap and no duplicate.

Illegal detection and field computation also meet in the same cycle. The bench sweeps every lsb from 0 to 31 and every width from 0 to 33 for all four field operations. For each case it judges the flag and the pass-through value against a bit-by-bit model.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    OP_CLR = 3'd0,
    OP_INS = 3'd1,
    OP_SXF = 3'd2,
    OP_UXF = 3'd3,
    OP_SXB = 3'd4,
    OP_SXH = 3'd5,
    OP_ZXB = 3'd6,
    OP_ZXH = 3'd7
  } bf_op_e;
endpackage

// File: rtl/bf_mask_gen.sv
module bf_mask_gen #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W),
  parameter int WID_W  = POS_W + 1
) (
  input  logic [POS_W-1:0]  lsb,
  input  logic [WID_W-1:0]  width,
  output logic [DATA_W-1:0] low_mask,
  output logic [DATA_W-1:0] field_mask,
  output logic              legal
);
  localparam logic [WID_W:0] END_LIMIT = (WID_W+1)'(DATA_W);

  logic [DATA_W:0] wide_ones;
  logic [WID_W:0]  end_pos;

  always_comb begin
    // one extra bit so a full-width field yields all ones
    wide_ones  = ({{DATA_W{1'b0}}, 1'b1} << width) - 1'b1;
    low_mask   = wide_ones[DATA_W-1:0];
    field_mask = low_mask << lsb;
    end_pos    = (WID_W+1)'(lsb) + (WID_W+1)'(width);
    legal      = (width != '0) && (end_pos <= END_LIMIT);
  end
endmodule

// File: rtl/bf_extend.sv
module bf_extend #(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 8
) (
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] sext,
  output logic [DATA_W-1:0] zext
);
  localparam int FILL_W = DATA_W - SUB_W;

  always_comb begin
    sext = {{FILL_W{src[SUB_W-1]}}, src[SUB_W-1:0]};
    zext = {{FILL_W{1'b0}}, src[SUB_W-1:0]};
  end
endmodule

// File: rtl/bf_field_ops.sv
module bf_field_ops
  import bf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  bf_op_e            op,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [POS_W-1:0]  lsb,
  input  logic [DATA_W-1:0] low_mask,
  input  logic [DATA_W-1:0] field_mask,
  input  logic              legal,
  input  logic [DATA_W-1:0] sx_byte,
  input  logic [DATA_W-1:0] sx_half,
  input  logic [DATA_W-1:0] zx_byte,
  input  logic [DATA_W-1:0] zx_half,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  logic [DATA_W-1:0] kept;
  logic [DATA_W-1:0] placed;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] ufield;
  logic [DATA_W-1:0] top_bit;
  logic              field_sign;
  logic              is_field;

  always_comb begin
    kept       = dst & ~field_mask;
    placed     = (src << lsb) & field_mask;
    shifted    = src >> lsb;
    ufield     = shifted & low_mask;
    // isolates bit (width-1) of the low-aligned field
    top_bit    = low_mask ^ (low_mask >> 1);
    field_sign = |(shifted & top_bit);
    is_field   = (op == OP_CLR) || (op == OP_INS) || (op == OP_SXF) || (op == OP_UXF);
    illegal    = is_field && !legal;

    unique case (op)
      OP_CLR:  result = kept;
      OP_INS:  result = kept | placed;
      OP_SXF:  result = ufield | (field_sign ? ~low_mask : '0);
      OP_UXF:  result = ufield;
      OP_SXB:  result = sx_byte;
      OP_SXH:  result = sx_half;
      OP_ZXB:  result = zx_byte;
      default: result = zx_half;
    endcase

    if (illegal) result = dst;
  end
endmodule

// File: rtl/bf_out_stage.sv
module bf_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] nxt_result,
  input  logic              nxt_illegal,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  logic take;

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_result  <= nxt_result;
        out_illegal <= nxt_illegal;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  localparam int POS_W = $clog2(DATA_W),
  localparam int WID_W = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [POS_W-1:0]  in_lsb,
  input  logic [WID_W-1:0]  in_width,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal,
  output logic              out_flag_we
);
  localparam int N_EXT = 2;

  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] field_mask;
  logic              legal;
  logic [DATA_W-1:0] ext_s [N_EXT];
  logic [DATA_W-1:0] ext_z [N_EXT];
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_illegal;
  bf_op_e            op;

  assign op          = bf_op_e'(in_op);
  assign out_flag_we = 1'b0;

  bf_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W), .WID_W(WID_W)) u_mask (
    .lsb        (in_lsb),
    .width      (in_width),
    .low_mask   (low_mask),
    .field_mask (field_mask),
    .legal      (legal)
  );

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    localparam int SW = (g == 0) ? BYTE_W : HALF_W;
    bf_extend #(.DATA_W(DATA_W), .SUB_W(SW)) u_ext (
      .src  (in_src),
      .sext (ext_s[g]),
      .zext (ext_z[g])
    );
  end

  bf_field_ops #(.DATA_W(DATA_W), .POS_W(POS_W)) u_ops (
    .op         (op),
    .dst        (in_dst),
    .src        (in_src),
    .lsb        (in_lsb),
    .low_mask   (low_mask),
    .field_mask (field_mask),
    .legal      (legal),
    .sx_byte    (ext_s[0]),
    .sx_half    (ext_s[1]),
    .zx_byte    (ext_z[0]),
    .zx_half    (ext_z[1]),
    .result     (nxt_result),
    .illegal    (nxt_illegal)
  );

  bf_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .nxt_result  (nxt_result),
    .nxt_illegal (nxt_illegal),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
  );
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W),
  parameter int WID_W  = POS_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_dst,
  input logic [POS_W-1:0]  in_lsb,
  input logic [WID_W-1:0]  in_width,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal,
  input logic              out_flag_we
);
  localparam logic [WID_W:0] END_LIMIT = (WID_W+1)'(DATA_W);

  logic           fire;
  logic           field_op;
  logic [WID_W:0] end_pos;
  logic           bad_pair;

  assign fire     = in_valid && in_ready;
  assign field_op = !in_op[2];
  assign end_pos  = (WID_W+1)'(in_lsb) + (WID_W+1)'(in_width);
  assign bad_pair = (in_width == '0) || (end_pos > END_LIMIT);

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  // R9
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  illegal_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && field_op && bad_pair) |=> (out_illegal && out_result == $past(in_dst)));

  // R6
  legal_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && field_op && !bad_pair) |=> !out_illegal);

  // R7
  extend_never_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !field_op) |=> !out_illegal);

  // R10
  reset_empties_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R11
  always_comb begin
    flag_we_low_chk: assert (out_flag_we == 1'b0);
  end
endmodule

bind bitfield_unit bitfield_unit_chk #(.DATA_W(DATA_W), .POS_W(POS_W), .WID_W(WID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_dst      (in_dst),
  .in_lsb      (in_lsb),
  .in_width    (in_width),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal),
  .out_flag_we (out_flag_we)
);

// File: tb/bitfield_unit_tb.sv
`timescale 1ns/1ps
module bitfield_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_op;
  logic [31:0] in_dst;
  logic [31:0] in_src;
  logic [4:0]  in_lsb;
  logic [5:0]  in_width;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_result;
  logic        out_illegal;
  logic        out_flag_we;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bitfield_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src(in_src), .in_lsb(in_lsb),
    .in_width(in_width), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal), .out_flag_we(out_flag_we)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_bad_pair(int op, int lsb, int wid);
    return (op < 4) && (wid == 0 || lsb + wid > 32);
  endfunction

  function automatic logic [31:0] model(int op, logic [31:0] d, logic [31:0] s, int lsb, int wid);
    logic [31:0] r;
    if (is_bad_pair(op, lsb, wid)) return d;
    for (int i = 0; i < 32; i++) begin
      case (op)
        0: r[i] = (i >= lsb && i < lsb + wid) ? 1'b0 : d[i];
        1: r[i] = (i >= lsb && i < lsb + wid) ? s[i - lsb] : d[i];
        2: r[i] = (i < wid) ? s[lsb + i] : s[lsb + wid - 1];
        3: r[i] = (i < wid) ? s[lsb + i] : 1'b0;
        4: r[i] = (i < 8) ? s[i] : s[7];
        5: r[i] = (i < 16) ? s[i] : s[15];
        6: r[i] = (i < 8) ? s[i] : 1'b0;
        default: r[i] = (i < 16) ? s[i] : 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R1 clear";
      1: return "R2 insert";
      2: return "R4 signed extract";
      3: return "R3 unsigned extract";
      default: return "R5/R7 extend";
    endcase
  endfunction

  task automatic put(int op, logic [31:0] d, logic [31:0] s, int lsb, int wid);
    in_op = 3'(op); in_dst = d; in_src = s; in_lsb = 5'(lsb); in_width = 6'(wid);
  endtask

  task automatic run(int op, logic [31:0] d, logic [31:0] s, int lsb, int wid);
    @(negedge clk);
    put(op, d, s, lsb, wid);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 out_valid", 32'(out_valid), 32'd1);
    check(tag_of(op), out_result, model(op, d, s, lsb, wid));
    check("R6 illegal flag", 32'(out_illegal), 32'(is_bad_pair(op, lsb, wid)));
    check("R11 flag_we", 32'(out_flag_we), 32'd0);
  endtask

  initial begin
    logic [31:0] dpat [2];
    logic [31:0] spat [2];
    dpat[0] = 32'h0F0F_3C5A; spat[0] = 32'hC3A5_96E1;
    dpat[1] = 32'hF0F0_C3A5; spat[1] = 32'h3C5A_691E;

    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    put(0, '0, '0, 0, 0);
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", 32'(out_valid), 32'd0);
    check("R11 reset flag_we", 32'(out_flag_we), 32'd0);
    rst = 1'b0;

    // R1 R2 R3 R4 R6: full lsb/width sweep of field operations
    for (int p = 0; p < 2; p++)
      for (int op = 0; op < 4; op++)
        for (int lsb = 0; lsb < 32; lsb++)
          for (int wid = 0; wid < 34; wid++)
            run(op, dpat[p] ^ 32'(lsb * 32'h0101_0101), spat[p] ^ 32'(wid * 32'h1001_0010), lsb, wid);

    // R5 R7: extends over all byte values, with nonsense lsb/width
    for (int op = 4; op < 8; op++)
      for (int v = 0; v < 256; v++)
        run(op, 32'hDEAD_BEEF, {8'(v), 8'(~v), 8'(v ^ 8'h5A), 8'(v)}, (v * 7) % 32, (v % 3 == 0) ? 0 : 33);

    // R9: stall, then drain and accept on the same edge
    @(negedge clk);
    put(1, 32'h1111_1111, 32'h0000_00AB, 4, 8);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    put(0, 32'hFFFF_FFFF, 32'h0, 8, 16);
    check("R8 stalled valid", 32'(out_valid), 32'd1);
    check("R9 in_ready low", 32'(in_ready), 32'd0);
    check("R9 first result", out_result, 32'h1111_1AB1);
    repeat (2) @(negedge clk);
    check("R9 held result", out_result, 32'h1111_1AB1);
    check("R9 held valid", 32'(out_valid), 32'd1);
    check("R9 held illegal", 32'(out_illegal), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second result", out_result, 32'hFF00_00FF);
    check("R9 second valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R8 drained", 32'(out_valid), 32'd0);

    // R10: reset empties a stalled output
    put(3, 32'h0, 32'hFFFF_FFFF, 0, 4);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 pre-reset valid", 32'(out_valid), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 cleared valid", 32'(out_valid), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule